// File: doc/BRIEF.md
# PWM/DIR H-Bridge Gate Command Decoder

This block takes a two-wire motor command, a speed line (`pwm_i`) and a direction line (`dir_i`), and turns it into on/off requests for the four switches of a full H-bridge built from two half-bridges (legs). Direction selects which leg is modulated. While the speed line is low, both high-side switches are on and the motor brakes through them. A driver-disable line and a force-off line from the protection logic switch the whole bridge off.

Each leg has its own controller. The controller turns a switch off at once. It turns the partner switch on only after a programmable number of idle cycles with both switches of the leg off. The dead time comes from `dt_cycles_i`, or is at its maximum when `dt_open_i` says the setting is unconfigured. For each switch the block also gives a flag that rises once the switch has been on for the length of the dead time. Downstream short-circuit blanking logic uses this flag. There are no data streams, so no valid/ready handshakes: every pin is plain level control or status, and all gate requests come from registers.

Top module: `hbd_top`

## Requirements
- R1: With disable and force-off low and PWM=0, the steady state for either DIR has both high-side requests on and both low-side requests off.
- R2: With disable and force-off low, DIR=0 and PWM=1, the steady state has high-side 1 and low-side 2 on, and high-side 2 and low-side 1 off.
- R3: With disable and force-off low, DIR=1 and PWM=1, the steady state has low-side 1 and high-side 2 on, and high-side 1 and low-side 2 off.
- R4: Disable high at a rising clock edge leaves all four requests off after that edge, whatever PWM and DIR are.
- R5: Force-off high at a rising edge leaves all four requests off after that edge and resets the leg's idle count. After release, a leg needs a fresh dead time before it switches on again.
- R6: The high-side and low-side request of one leg are never on in the same cycle.
- R7: When a leg's target changes from one switch to the other, both requests of the leg stay off for exactly D+1 clock cycles, where D is the effective setting. A setting of 0 gives the minimum gap of one cycle.
- R8: With `dt_open_i` high, D is the all-ones value of the setting width (255 for the default width of 8), so the gap is 256 cycles.
- R9: If a leg's target changes while its idle count has not yet reached D, the count starts again from zero. Example: D=5, the target changes after 3 idle cycles, and the leg stays off 9 cycles in total.
- R10: `armed_o` bit order is {low-side 2, high-side 2, low-side 1, high-side 1}. A bit is never high while its switch is off. It rises after the switch has been on for D cycles, so it is low for the first D on-cycles.
- R11: During and right after reset all requests and flags are low. The first turn-on after reset follows a full dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Speed/modulation command |
| dir_i | input | 1 | Direction: picks the modulated leg |
| drv_off_i | input | 1 | Driver disable; all switches off |
| prot_kill_i | input | 1 | Force-off request from protection logic |
| dt_cycles_i | input | DT_W | Dead-time setting D in clock cycles |
| dt_open_i | input | 1 | Setting unconfigured; use maximum D |
| hs1_on_o | output | 1 | High-side 1 on request |
| ls1_on_o | output | 1 | Low-side 1 on request |
| hs2_on_o | output | 1 | High-side 2 on request |
| ls2_on_o | output | 1 | Low-side 2 on request |
| armed_o | output | 4 | Per-switch on-and-dead-time-elapsed flags |

## Verification
Each leg's state is a current output, an idle/on counter and the last target seen. A corrupt counter shows up at the ports within one dead time, as an off gap that is too short or too long, or as an armed flag that rises early or late. A wrong leg state gives a mismatched or overlapping gate request on the very next cycle. A reference model in the bench tracks each leg cycle by cycle and compares all eight outputs every cycle. Directed cases measure gap lengths for settings 3, 5 and the open maximum, and the restart after a mid-gap retarget.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int LEGS = 2;

  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HI  = 2'b01,
    LEG_LO  = 2'b10
  } leg_cmd_e;
endpackage

// File: rtl/hbd_cmd_map.sv
module hbd_cmd_map
  import hbd_pkg::*;
(
  input  logic     pwm_i,
  input  logic     dir_i,
  input  logic     drv_off_i,
  output leg_cmd_e leg0_tgt_o,
  output leg_cmd_e leg1_tgt_o
);
  // Modulated leg is picked by direction; PWM low brakes through both high sides.
  always_comb begin
    leg0_tgt_o = LEG_HI;
    leg1_tgt_o = LEG_HI;
    if (drv_off_i) begin
      leg0_tgt_o = LEG_OFF;
      leg1_tgt_o = LEG_OFF;
    end else if (pwm_i) begin
      if (dir_i) leg0_tgt_o = LEG_LO;
      else       leg1_tgt_o = LEG_LO;
    end
  end
endmodule

// File: rtl/hbd_leg.sv
module hbd_leg
  import hbd_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            kill_i,
  input  leg_cmd_e        tgt_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            hi_on_o,
  output logic            lo_on_o,
  output logic            hi_arm_o,
  output logic            lo_arm_o
);
  localparam logic [DT_W-1:0] CNT_SAT = {DT_W{1'b1}};

  leg_cmd_e        state_q, tgt_q;
  logic [DT_W-1:0] cnt_q;
  logic            cnt_done;

  assign cnt_done = (cnt_q >= dt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LEG_OFF;
      tgt_q   <= LEG_OFF;
      cnt_q   <= '0;
    end else begin
      tgt_q <= tgt_i;
      if (kill_i) begin
        state_q <= LEG_OFF;
        cnt_q   <= '0;
      end else if (state_q != LEG_OFF && tgt_i != state_q) begin
        state_q <= LEG_OFF;
        cnt_q   <= '0;
      end else if (state_q == LEG_OFF && tgt_i != LEG_OFF && cnt_done) begin
        state_q <= tgt_i;
        cnt_q   <= '0;
      end else if (state_q == LEG_OFF && tgt_i != tgt_q && !cnt_done) begin
        cnt_q <= '0;
      end else if (cnt_q != CNT_SAT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hi_on_o  = (state_q == LEG_HI);
  assign lo_on_o  = (state_q == LEG_LO);
  assign hi_arm_o = hi_on_o && cnt_done;
  assign lo_arm_o = lo_on_o && cnt_done;
endmodule

// File: rtl/hbd_top.sv
module hbd_top
  import hbd_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwm_i,
  input  logic            dir_i,
  input  logic            drv_off_i,
  input  logic            prot_kill_i,
  input  logic [DT_W-1:0] dt_cycles_i,
  input  logic            dt_open_i,
  output logic            hs1_on_o,
  output logic            ls1_on_o,
  output logic            hs2_on_o,
  output logic            ls2_on_o,
  output logic [3:0]      armed_o
);
  localparam logic [DT_W-1:0] DT_MAX = {DT_W{1'b1}};

  leg_cmd_e        tgt [LEGS];
  logic [LEGS-1:0] hi_on, lo_on, hi_arm, lo_arm;
  logic [DT_W-1:0] dt_eff;

  assign dt_eff = dt_open_i ? DT_MAX : dt_cycles_i;

  hbd_cmd_map u_map (
    .pwm_i      (pwm_i),
    .dir_i      (dir_i),
    .drv_off_i  (drv_off_i),
    .leg0_tgt_o (tgt[0]),
    .leg1_tgt_o (tgt[1])
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hbd_leg #(.DT_W(DT_W)) u_leg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .kill_i   (prot_kill_i),
      .tgt_i    (tgt[g]),
      .dt_i     (dt_eff),
      .hi_on_o  (hi_on[g]),
      .lo_on_o  (lo_on[g]),
      .hi_arm_o (hi_arm[g]),
      .lo_arm_o (lo_arm[g])
    );
  end

  assign hs1_on_o = hi_on[0];
  assign ls1_on_o = lo_on[0];
  assign hs2_on_o = hi_on[1];
  assign ls2_on_o = lo_on[1];
  assign armed_o  = {lo_arm[1], hi_arm[1], lo_arm[0], hi_arm[0]};
endmodule

// File: rtl/hbd_chk.sv
module hbd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       drv_off_i,
  input logic       prot_kill_i,
  input logic       hs1_on_o,
  input logic       ls1_on_o,
  input logic       hs2_on_o,
  input logic       ls2_on_o,
  input logic [3:0] armed_o
);
  logic any_on;
  assign any_on = hs1_on_o | ls1_on_o | hs2_on_o | ls2_on_o;

  AST_LEG1_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs1_on_o && ls1_on_o)); // R6
  AST_LEG2_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs2_on_o && ls2_on_o)); // R6
  AST_DISABLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_off_i |=> !any_on); // R4
  AST_KILL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_kill_i |=> !any_on); // R5
  AST_LEG1_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs1_on_o) || $rose(ls1_on_o)) |-> !$past(hs1_on_o || ls1_on_o)); // R7
  AST_LEG2_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs2_on_o) || $rose(ls2_on_o)) |-> !$past(hs2_on_o || ls2_on_o)); // R7
  AST_ARM_NEEDS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o & ~{ls2_on_o, hs2_on_o, ls1_on_o, hs1_on_o}) == 4'b0000); // R10
endmodule

bind hbd_top hbd_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .drv_off_i   (drv_off_i),
  .prot_kill_i (prot_kill_i),
  .hs1_on_o    (hs1_on_o),
  .ls1_on_o    (ls1_on_o),
  .hs2_on_o    (hs2_on_o),
  .ls2_on_o    (ls2_on_o),
  .armed_o     (armed_o)
);

// File: tb/test_hbd_top.sv
module test_hbd_top;
  localparam int CLK_PERIOD = 10;
  localparam int DT_W = 8;
  localparam int DMAX = (1 << DT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, dir = 1'b0, dis = 1'b0, kill = 1'b0, dt_open = 1'b0;
  logic [DT_W-1:0] dt = 8'd3;
  logic hs1, ls1, hs2, ls2;
  logic [3:0] armed;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbd_top #(.DT_W(DT_W)) i_hbd_top (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .dir_i(dir),
    .drv_off_i(dis), .prot_kill_i(kill), .dt_cycles_i(dt), .dt_open_i(dt_open),
    .hs1_on_o(hs1), .ls1_on_o(ls1), .hs2_on_o(hs2), .ls2_on_o(ls2),
    .armed_o(armed)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: per leg, 0=off 1=high on 2=low on
  int m_out [2];
  int m_cnt [2];
  int m_tq  [2];

  function automatic int dt_now();
    return dt_open ? DMAX : int'(dt);
  endfunction

  function automatic int want(input int leg);
    if (dis) return 0;
    if (!pwm) return 1;
    if (leg == 0) return dir ? 2 : 1;
    return dir ? 1 : 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) begin m_out[l] = 0; m_cnt[l] = 0; m_tq[l] = 0; end
    end else begin
      for (int l = 0; l < 2; l++) begin
        int t;
        int d;
        t = want(l);
        d = dt_now();
        if (kill) begin m_out[l] = 0; m_cnt[l] = 0; end
        else if (m_out[l] != 0 && t != m_out[l]) begin m_out[l] = 0; m_cnt[l] = 0; end
        else if (m_out[l] == 0 && t != 0 && m_cnt[l] >= d) begin m_out[l] = t; m_cnt[l] = 0; end
        else if (m_out[l] == 0 && t != m_tq[l] && m_cnt[l] < d) m_cnt[l] = 0;
        else if (m_cnt[l] < DMAX) m_cnt[l]++;
        m_tq[l] = t;
      end
    end
  end

  // Per-cycle comparison against the model (R6, R7, R9, R10 in every cycle)
  always @(negedge clk) begin
    if (rst_n) begin
      int d;
      logic [3:0] eg, ea;
      d = dt_now();
      eg = {m_out[1] == 2, m_out[1] == 1, m_out[0] == 2, m_out[0] == 1};
      ea = eg & {m_cnt[1] >= d, m_cnt[1] >= d, m_cnt[0] >= d, m_cnt[0] >= d};
      check({ls2, hs2, ls1, hs1} == eg, "R7 gate requests vs model", {ls2, hs2, ls1, hs1}, eg);
      check(armed == ea, "R10 armed flags vs model", armed, ea);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(input logic p, input logic d, input logic ds);
    @(negedge clk); #1;
    pwm = p; dir = d; dis = ds;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit leg_off(input int l);
    return (l == 0) ? !(hs1 || ls1) : !(hs2 || ls2);
  endfunction

  task automatic count_off(input int l, output int offs);
    offs = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (leg_off(l)) offs++;
      else break;
    end
  endtask

  initial begin
    int offs;
    int unarmed;
    settle(3);
    check({hs1, ls1, hs2, ls2, armed} == 8'h00, "R11 reset state", {hs1, ls1, hs2, ls2, armed}, 0);
    @(negedge clk); #1; rst_n = 1'b1;
    // First turn-on after reset needs D+1 idle cycles (D=3)
    count_off(0, offs);
    check(offs == 4, "R11 first turn-on delay", offs, 4);
    settle(8);
    check({hs1, ls1, hs2, ls2} == 4'b1010, "R1 brake DIR=0", {hs1, ls1, hs2, ls2}, 4'b1010);

    // R7 gap and R10 armed timing, leg 2 going HI->LO with D=3
    drive(1, 0, 0);
    count_off(1, offs);
    check(offs == 4, "R7 dead gap D=3", offs, 4);
    unarmed = 0;
    for (int i = 0; i < 20; i++) begin
      if (ls2 && !armed[3]) unarmed++;
      @(negedge clk);
    end
    check(unarmed == 3, "R10 unarmed on-cycles", unarmed, 3);
    check({hs1, ls1, hs2, ls2} == 4'b1001, "R2 DIR=0 PWM=1", {hs1, ls1, hs2, ls2}, 4'b1001);
    check(armed == 4'b1001, "R10 flags in steady state", armed, 4'b1001);

    // R3 direction reversal
    drive(1, 1, 0);
    settle(12);
    check({hs1, ls1, hs2, ls2} == 4'b0110, "R3 DIR=1 PWM=1", {hs1, ls1, hs2, ls2}, 4'b0110);
    drive(0, 1, 0);
    settle(12);
    check({hs1, ls1, hs2, ls2} == 4'b1010, "R1 brake DIR=1", {hs1, ls1, hs2, ls2}, 4'b1010);

    // R4 disable
    drive(1, 1, 1);
    @(negedge clk);
    check({hs1, ls1, hs2, ls2, armed} == 8'h00, "R4 disable all off", {hs1, ls1, hs2, ls2, armed}, 0);
    settle(5);
    drive(0, 0, 0);
    settle(12);

    // R5 force-off pulse then fresh dead time
    @(negedge clk); #1; kill = 1'b1;
    @(negedge clk); #1; kill = 1'b0;
    check({hs1, ls1, hs2, ls2} == 4'b0000, "R5 force-off", {hs1, ls1, hs2, ls2}, 0);
    count_off(0, offs);
    check(offs == 3, "R5 re-arm after force-off", offs + 1, 4);
    settle(10);

    // R7 minimum gap with D=0
    @(negedge clk); #1; dt = 8'd0;
    drive(1, 0, 0);
    count_off(1, offs);
    check(offs == 1, "R7 minimum gap D=0", offs, 1);
    drive(0, 0, 0);
    settle(6);

    // R9 restart on retarget mid-gap, D=5
    @(negedge clk); #1; dt = 8'd5;
    settle(3);
    drive(1, 1, 0);
    offs = 0;
    repeat (3) begin @(negedge clk); if (leg_off(0)) offs++; end
    #1; pwm = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (leg_off(0)) offs++; else break;
    end
    check(offs == 9, "R9 restarted gap", offs, 9);
    check(hs1 == 1'b1, "R9 ends on retarget", hs1, 1);
    settle(8);

    // R8 open setting gives maximum gap
    @(negedge clk); #1; dt_open = 1'b1;
    settle(2);
    drive(1, 0, 0);
    count_off(1, offs);
    check(offs == DMAX + 1, "R8 open maximum gap", offs, DMAX + 1);
    @(negedge clk); #1; dt_open = 1'b0; dt = 8'd2;
    settle(6);

    // Mixed stimulus, compared every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      pwm  = $urandom_range(0, 3) != 0 ? ~pwm : pwm;
      dir  = ($urandom_range(0, 15) == 0) ? ~dir : dir;
      dis  = ($urandom_range(0, 40) == 0);
      kill = ($urandom_range(0, 60) == 0);
      if ($urandom_range(0, 50) == 0) dt = 8'($urandom_range(0, 6));
      dt_open = ($urandom_range(0, 300) == 0) ? ~dt_open : dt_open;
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule